// File: doc/BRIEF.md
# Battery-Low Power Mode Trigger

This block watches two active-low battery warnings and an AC-present level, and asks the power management state machine to change mode. The milder warning asks for Sleep and the critical warning asks for Suspend. Each of these mode requests has its own mask bit, which is written through a simple write strobe. While AC power is present, neither request is made. Every request is a single-cycle pulse.

The milder warning also raises an SMI request pulse and drives a live status level for the CPU to read. These two outputs depend only on the warning input. The mask bits and AC presence do not change them. All three inputs pass through a two-stage synchronizer, and the block acts only on a synchronized falling edge of a warning. A warning that stays low therefore produces one set of pulses.

Top module: `batlow_trigger`

## Requirements
- R1: When the synchronized `warn_lo_n` falls while the synchronized `ac_present` is 0 and `mask_lo` is 0, `sleep_req` pulses high for one cycle. This happens unless R7 suppresses the pulse.
- R2: When the synchronized `warn_crit_n` falls while the synchronized `ac_present` is 0 and `mask_crit` is 0, `suspend_req` pulses high for one cycle.
- R3: If a mask bit is 1, its warning does not produce its mode request. A rising edge of `clk` with `cfg_we`=1 loads `mask_lo` from `cfg_mask_lo` and `mask_crit` from `cfg_mask_crit`.
- R4: Every synchronized falling edge of `warn_lo_n` produces a one-cycle `smi_req` pulse. The mask bits and `ac_present` have no effect on this pulse.
- R5: `warn_lo_stat` is 1 while the synchronized `warn_lo_n` is 0, and 0 otherwise. The mask bits have no effect on it.
- R6: Reset clears both mask bits to 0, so both mode requests are enabled. During and after reset all pulse outputs are 0 and `warn_lo_stat` is 0 while the warning input is high.
- R7: If both warnings fall in the same cycle and both would request a mode change, only `suspend_req` pulses. `sleep_req` and `suspend_req` are never high together.
- R8: Timing, for an input that changes before rising edge k:
  - a request or SMI pulse is high between edges k+2 and k+3;
  - `warn_lo_stat` changes at edge k+1;
  - a warning held low gives exactly one pulse.
- R9: If AC power goes away while a warning is already being held low, no mode request follows. A request needs an edge of the warning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warn_lo_n | input | 1 | Low-threshold battery warning, active low, asynchronous |
| warn_crit_n | input | 1 | Critical battery warning, active low, asynchronous |
| ac_present | input | 1 | AC power present, asynchronous |
| cfg_we | input | 1 | Mask register write strobe |
| cfg_mask_lo | input | 1 | Write data for the Sleep-request mask |
| cfg_mask_crit | input | 1 | Write data for the Suspend-request mask |
| sleep_req | output | 1 | One-cycle Sleep request |
| suspend_req | output | 1 | One-cycle Suspend request |
| smi_req | output | 1 | One-cycle SMI request for the low-threshold warning |
| warn_lo_stat | output | 1 | Synchronized live status of the low-threshold warning |

## Verification
An input changed between two rising edges takes three edges to reach a pulse output: two synchronizer stages and one output register. It takes two edges to reach `warn_lo_stat`. The bench changes inputs on falling edges. It then checks the following, each sampled just after a rising edge:
- after the second edge, no pulse has appeared early and the status has already moved;
- after the third edge, each pulse output matches its expected value;
- over a further window, the number of pulses is counted to confirm that there is only one.

Before each warning event, the bench waits long enough for the mask and AC settings to pass through their own synchronizer and register.

// File: rtl/batlow_trigger.sv
module batlow_trigger #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_lo_n,
  input  logic warn_crit_n,
  input  logic ac_present,
  input  logic cfg_we,
  input  logic cfg_mask_lo,
  input  logic cfg_mask_crit,
  output logic sleep_req,
  output logic suspend_req,
  output logic smi_req,
  output logic warn_lo_stat
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] lo_sh, crit_sh, ac_sh;
  logic         lo_prev, crit_prev;
  logic         mask_lo_q, mask_crit_q;
  logic         lo_s, crit_s, ac_s;
  logic         lo_fall, crit_fall, want_susp, want_sleep;

  assign lo_s   = lo_sh[TOP];
  assign crit_s = crit_sh[TOP];
  assign ac_s   = ac_sh[TOP];

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_sh   <= '1;
          crit_sh <= '1;
          ac_sh   <= '0;
        end else begin
          lo_sh   <= {lo_sh[TOP-1:0], warn_lo_n};
          crit_sh <= {crit_sh[TOP-1:0], warn_crit_n};
          ac_sh   <= {ac_sh[TOP-1:0], ac_present};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_sh   <= '1;
          crit_sh <= '1;
          ac_sh   <= '0;
        end else begin
          lo_sh   <= warn_lo_n;
          crit_sh <= warn_crit_n;
          ac_sh   <= ac_present;
        end
      end
    end
  endgenerate

  assign lo_fall    = lo_prev & ~lo_s;
  assign crit_fall  = crit_prev & ~crit_s;
  assign want_susp  = crit_fall & ~ac_s & ~mask_crit_q;
  assign want_sleep = lo_fall & ~ac_s & ~mask_lo_q & ~want_susp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_prev     <= 1'b1;
      crit_prev   <= 1'b1;
      mask_lo_q   <= 1'b0;
      mask_crit_q <= 1'b0;
      sleep_req   <= 1'b0;
      suspend_req <= 1'b0;
      smi_req     <= 1'b0;
    end else begin
      lo_prev     <= lo_s;
      crit_prev   <= crit_s;
      if (cfg_we) begin
        mask_lo_q   <= cfg_mask_lo;
        mask_crit_q <= cfg_mask_crit;
      end
      sleep_req   <= want_sleep;
      suspend_req <= want_susp;
      smi_req     <= lo_fall;
    end
  end

  assign warn_lo_stat = ~lo_s;

endmodule

module batlow_trigger_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_req,
  input logic suspend_req,
  input logic smi_req,
  input logic warn_lo_stat,
  input logic mask_lo_q,
  input logic mask_crit_q,
  input logic ac_s
);

  AST_SLEEP_NO_AC:   assert property (@(posedge clk) disable iff (!rst_n) sleep_req |-> !$past(ac_s)); // R1
  AST_SUSP_NO_AC:    assert property (@(posedge clk) disable iff (!rst_n) suspend_req |-> !$past(ac_s)); // R2
  AST_SLEEP_MASKED:  assert property (@(posedge clk) disable iff (!rst_n) sleep_req |-> !$past(mask_lo_q)); // R3
  AST_SUSP_MASKED:   assert property (@(posedge clk) disable iff (!rst_n) suspend_req |-> !$past(mask_crit_q)); // R3
  AST_SLEEP_HAS_SMI: assert property (@(posedge clk) disable iff (!rst_n) sleep_req |-> smi_req); // R4
  AST_SMI_STATUS:    assert property (@(posedge clk) disable iff (!rst_n) smi_req |-> $past(warn_lo_stat)); // R5
  AST_REQ_EXCL:      assert property (@(posedge clk) disable iff (!rst_n) !(sleep_req && suspend_req)); // R7
  AST_SMI_ONE:       assert property (@(posedge clk) disable iff (!rst_n) smi_req |=> !smi_req); // R8
  AST_SLEEP_ONE:     assert property (@(posedge clk) disable iff (!rst_n) sleep_req |=> !sleep_req); // R8
  AST_SUSP_ONE:      assert property (@(posedge clk) disable iff (!rst_n) suspend_req |=> !suspend_req); // R8

endmodule

bind batlow_trigger batlow_trigger_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .suspend_req(suspend_req),
  .smi_req(smi_req), .warn_lo_stat(warn_lo_stat), .mask_lo_q(mask_lo_q),
  .mask_crit_q(mask_crit_q), .ac_s(ac_s)
);

// File: tb/tb_batlow_trigger.sv
module tb_batlow_trigger;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic warn_lo_n = 1'b1, warn_crit_n = 1'b1, ac_present = 1'b0;
  logic cfg_we = 1'b0, cfg_mask_lo = 1'b0, cfg_mask_crit = 1'b0;
  logic sleep_req, suspend_req, smi_req, warn_lo_stat;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  batlow_trigger dut (
    .clk(clk), .rst_n(rst_n), .warn_lo_n(warn_lo_n), .warn_crit_n(warn_crit_n),
    .ac_present(ac_present), .cfg_we(cfg_we), .cfg_mask_lo(cfg_mask_lo),
    .cfg_mask_crit(cfg_mask_crit), .sleep_req(sleep_req), .suspend_req(suspend_req),
    .smi_req(smi_req), .warn_lo_stat(warn_lo_stat)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_masks(input logic ml, input logic mc);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mask_lo = ml; cfg_mask_crit = mc;
    @(negedge clk);
    cfg_we = 1'b0; cfg_mask_lo = 1'b0; cfg_mask_crit = 1'b0;
  endtask

  task automatic run_case(input string req, input int ac, input int ml, input int mc,
                          input int ev_lo, input int ev_crit);
    int e_susp, e_sleep, e_smi;
    int n_sleep = 0, n_susp = 0, n_smi = 0;
    e_susp  = (ev_crit != 0 && ac == 0 && mc == 0) ? 1 : 0;
    e_sleep = (ev_lo != 0 && ac == 0 && ml == 0 && e_susp == 0) ? 1 : 0;
    e_smi   = ev_lo;
    @(negedge clk);
    ac_present = ac[0];
    tick(4);
    @(negedge clk);
    if (ev_lo != 0) warn_lo_n = 1'b0;
    if (ev_crit != 0) warn_crit_n = 1'b0;
    tick(2);
    chk(req, "early sleep_req", int'(sleep_req), 0);
    chk(req, "early suspend_req", int'(suspend_req), 0);
    chk("R5", "warn_lo_stat after two edges", int'(warn_lo_stat), ev_lo);
    tick(1);
    chk(req, "sleep_req third edge", int'(sleep_req), e_sleep);
    chk(req, "suspend_req third edge", int'(suspend_req), e_susp);
    chk("R4", "smi_req third edge", int'(smi_req), e_smi);
    for (int i = 0; i < 6; i++) begin
      n_sleep += int'(sleep_req); n_susp += int'(suspend_req); n_smi += int'(smi_req);
      tick(1);
    end
    chk("R8", "sleep pulse count while held", n_sleep, e_sleep);
    chk("R8", "suspend pulse count while held", n_susp, e_susp);
    chk("R8", "smi pulse count while held", n_smi, e_smi);
    chk("R5", "warn_lo_stat while held", int'(warn_lo_stat), ev_lo);
    @(negedge clk);
    warn_lo_n = 1'b1; warn_crit_n = 1'b1;
    tick(4);
    chk("R5", "warn_lo_stat released", int'(warn_lo_stat), 0);
  endtask

  initial begin
    int n_req;
    tick(2);
    chk("R6", "reset sleep_req", int'(sleep_req), 0);
    chk("R6", "reset suspend_req", int'(suspend_req), 0);
    chk("R6", "reset smi_req", int'(smi_req), 0);
    chk("R6", "reset warn_lo_stat", int'(warn_lo_stat), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(2);
    run_case("R6", 0, 0, 0, 1, 0);
    run_case("R6", 0, 0, 0, 0, 1);
    for (int ac = 0; ac < 2; ac++)
      for (int ml = 0; ml < 2; ml++)
        for (int mc = 0; mc < 2; mc++)
          for (int ev = 1; ev < 4; ev++) begin
            set_masks(ml[0], mc[0]);
            run_case(ev == 3 ? "R7" : (ml + mc != 0 ? "R3" : (ev == 1 ? "R1" : "R2")),
                     ac, ml, mc, ev & 1, ev >> 1);
          end
    set_masks(1'b0, 1'b0);
    @(negedge clk);
    ac_present = 1'b1;
    tick(4);
    @(negedge clk);
    warn_lo_n = 1'b0; warn_crit_n = 1'b0;
    tick(4);
    @(negedge clk);
    ac_present = 1'b0;
    n_req = 0;
    for (int i = 0; i < 8; i++) begin
      tick(1);
      n_req += int'(sleep_req) + int'(suspend_req);
    end
    chk("R9", "requests after AC loss while held", n_req, 0);
    @(negedge clk);
    warn_lo_n = 1'b1; warn_crit_n = 1'b1;
    tick(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule